// File: doc/BRIEF.md
# Oversampled Serial Receiver with Three-Entry Character Queue

This block turns an asynchronous serial line into bytes. It uses a per-bit oversample strobe, sixteen strobes per bit, that some other block supplies. Each frame has one low start bit, eight data bits with the least significant bit first, and one high stop bit. Each received character goes into a small queue along with two status bits. One bit says the stop bit was bad. The other says that a later character was lost because the queue was full. The consumer sees the oldest character and its status bits on the read side. It removes that character with a one-cycle read strobe.

When the queue already holds three unread characters and another start bit is confirmed, the receiver drops the incoming character and marks the newest stored character as overrun. That mark, and each character's stop-bit status, belong to the stored entry. A read issued while the dropped frame is still arriving cannot erase either bit or change it.

Top module: `uart_rx3`

## Requirements
- R1: While reset is asserted and after it is released, with no frame received, `rd_valid` is 0.
- R2: A frame made of a low start bit, eight data bits sent least significant bit first, and a stop bit is delivered as `rd_data` with `rd_valid` 1 once the stop bit has been sampled.
- R3: A low level that is no longer low at the middle of the start bit (samples 7, 8 and 9 of 16) is discarded, and no character is stored.
- R4: `rd_ferr` of an entry is 1 exactly when that character's own stop bit was sampled low, and 0 when it was high.
- R5: The queue holds up to three unread characters in arrival order. The third one is stored without an overrun mark.
- R6: If a start bit is confirmed while three characters are held and no read happens in that cycle, the newest stored entry gets `rd_ovr` = 1. The incoming character is dropped, and the three stored characters keep their data.
- R7: Reads issued while the dropped character is being received, including one just after its start bit, leave the overrun mark and the stop-bit status of the stored entries unchanged. The mark is shown once that entry reaches the head.
- R8: A read strobe while `rd_valid` is 1 removes the head. The next entry's data, `rd_ferr` and `rd_ovr` are presented in the following cycle.
- R9: A read strobe while the queue is empty has no effect.
- R10: Each bit is decided by majority over samples 7, 8 and 9 of its 16 oversamples. A single wrong sample at position 8 does not change the received bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Oversample strobe, 16 per bit time, one clock wide |
| rd_pop | input | 1 | Read strobe that removes the head entry |
| rd_data | output | 8 | Data of the head entry |
| rd_valid | output | 1 | Queue holds at least one character |
| rd_ferr | output | 1 | Stop-bit error of the head entry |
| rd_ovr | output | 1 | Overrun mark of the head entry |

## Verification
The receiver is driven with clean frames carrying random bytes, and with frames whose stop bit is low. This separates the data path from the stop-bit status. Runt start pulses show that mid-bit confirmation works. Frames with one sample flipped at position 8 show that the majority vote is used rather than a single sample. Directed fills to three entries, followed by a fourth frame, check when the overrun mark is attached and where. Reads placed just after the fourth start bit and in the middle of that frame show that the mark and the stop status survive concurrent reads. Random read bursts between frames check that the queue advances in order.

// File: rtl/uart_rx3_pkg.sv
package uart_rx3_pkg;

    parameter int unsigned DATA_BITS = 8;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 ferr;
        logic                 ovr;
    } rx_ent_t;

endpackage

// File: rtl/uart_rx3_sync.sv
module uart_rx3_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= sr_d;
    end

    assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx3_deser.sv
module uart_rx3_deser
    import uart_rx3_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx,
    input  logic                 tick,
    output logic                 start_ok,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 ferr
);
    localparam int unsigned CW = $clog2(OSR);
    localparam int unsigned BW = $clog2(DATA_BITS);
    localparam logic [CW-1:0] S_LO  = CW'(OSR/2 - 1);
    localparam logic [CW-1:0] S_MID = CW'(OSR/2);
    localparam logic [CW-1:0] S_HI  = CW'(OSR/2 + 1);
    localparam logic [BW-1:0] LAST  = BW'(DATA_BITS - 1);

    typedef struct packed {
        rx_state_e            st;
        logic [CW-1:0]        cnt;
        logic [BW-1:0]        bidx;
        logic [DATA_BITS-1:0] sh;
        logic [1:0]           vote;
        logic                 start_ok;
        logic                 done;
        logic                 ferr;
    } deser_t;

    deser_t s_d, s_q;
    logic [1:0] tally;
    logic       bit_v;

    always_comb begin
        s_d          = s_q;
        s_d.start_ok = 1'b0;
        s_d.done     = 1'b0;
        tally        = s_q.vote + {1'b0, rx};
        bit_v        = tally[1];
        if (tick) begin
            if (s_q.st == RX_IDLE) begin
                if (!rx) begin
                    s_d.st  = RX_START;
                    s_d.cnt = CW'(1);
                end
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == S_LO) begin
                    s_d.vote = {1'b0, rx};
                end else if (s_q.cnt == S_MID) begin
                    s_d.vote = tally;
                end else if (s_q.cnt == S_HI) begin
                    case (s_q.st)
                        RX_START: begin
                            if (!bit_v) begin
                                s_d.st       = RX_DATA;
                                s_d.bidx     = '0;
                                s_d.start_ok = 1'b1;
                            end else begin
                                s_d.st = RX_IDLE;
                            end
                        end
                        RX_DATA: begin
                            s_d.sh = {bit_v, s_q.sh[DATA_BITS-1:1]};
                            if (s_q.bidx == LAST) s_d.st = RX_STOP;
                            else                  s_d.bidx = s_q.bidx + 1'b1;
                        end
                        default: begin
                            s_d.done = 1'b1;
                            s_d.ferr = ~bit_v;
                            s_d.st   = RX_IDLE;
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign start_ok = s_q.start_ok;
    assign done     = s_q.done;
    assign data     = s_q.sh;
    assign ferr     = s_q.ferr;
endmodule

// File: rtl/uart_rx3_fifo.sv
module uart_rx3_fifo
    import uart_rx3_pkg::*;
#(
    parameter int unsigned DEPTH = 3,
    localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_ok,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] din,
    input  logic                 fe_in,
    input  logic                 pop,
    output rx_ent_t              head,
    output logic                 valid,
    output logic [CNTW-1:0]      cnt,
    output logic                 full,
    output logic                 push
);
    localparam logic [CNTW-1:0] FULLV = CNTW'(DEPTH);

    typedef struct packed {
        rx_ent_t [DEPTH-1:0] ent;
        logic [CNTW-1:0]     cnt;
        logic                drop;
    } fifo_t;

    fifo_t f_d, f_q;
    logic            pop_ok;
    logic            ovr_hit;
    logic [CNTW-1:0] base;

    always_comb begin
        f_d     = f_q;
        pop_ok  = pop && (f_q.cnt != '0);
        ovr_hit = start_ok && (f_q.cnt == FULLV) && !pop;
        base    = f_q.cnt - {{(CNTW-1){1'b0}}, pop_ok};
        push    = done && !f_q.drop && (base < FULLV);

        // removal is applied before any store
        if (pop_ok) begin
            for (int i = 0; i < DEPTH - 1; i++) f_d.ent[i] = f_q.ent[i+1];
            f_d.ent[DEPTH-1] = '0;
        end

        if (ovr_hit) begin
            f_d.ent[DEPTH-1].ovr = 1'b1;
            f_d.drop             = 1'b1;
        end else if (start_ok) begin
            f_d.drop = 1'b0;
        end
        if (done) f_d.drop = 1'b0;

        for (int i = 0; i < DEPTH; i++) begin
            if (push && base == CNTW'(i)) begin
                f_d.ent[i].data = din;
                f_d.ent[i].ferr = fe_in;
                f_d.ent[i].ovr  = 1'b0;
            end
        end
        f_d.cnt = push ? base + 1'b1 : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign head  = f_q.ent[0];
    assign valid = (f_q.cnt != '0);
    assign cnt   = f_q.cnt;
    assign full  = (f_q.cnt == FULLV);
endmodule

// File: rtl/uart_rx3.sv
module uart_rx3
    import uart_rx3_pkg::*;
#(
    parameter int unsigned OSR         = 16,
    parameter int unsigned DEPTH       = 3,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd,
    input  logic                 os_tick,
    input  logic                 rd_pop,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 rd_valid,
    output logic                 rd_ferr,
    output logic                 rd_ovr
);
    logic                 rx_s;
    logic                 st_ok;
    logic                 fr_done;
    logic [DATA_BITS-1:0] fr_data;
    logic                 fr_ferr;
    rx_ent_t              q_head;
    logic [CNTW-1:0]      q_cnt;
    logic                 q_full;
    logic                 q_push;

    uart_rx3_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    uart_rx3_deser #(.OSR(OSR)) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx      (rx_s),
        .tick    (os_tick),
        .start_ok(st_ok),
        .done    (fr_done),
        .data    (fr_data),
        .ferr    (fr_ferr)
    );

    uart_rx3_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_ok(st_ok),
        .done    (fr_done),
        .din     (fr_data),
        .fe_in   (fr_ferr),
        .pop     (rd_pop),
        .head    (q_head),
        .valid   (rd_valid),
        .cnt     (q_cnt),
        .full    (q_full),
        .push    (q_push)
    );

    assign rd_data = q_head.data;
    assign rd_ferr = q_head.ferr;
    assign rd_ovr  = q_head.ovr;
endmodule

// File: rtl/uart_rx3_chk.sv
module uart_rx3_chk #(
    parameter int unsigned DEPTH = 3,
    parameter int unsigned DW    = 8,
    localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_pop,
    input logic            rd_valid,
    input logic            rd_ferr,
    input logic            rd_ovr,
    input logic [DW-1:0]   rd_data,
    input logic            st_ok,
    input logic [CNTW-1:0] q_cnt,
    input logic            q_full,
    input logic            q_push
);
    // R1
    a_r1_reset_empty: assert property (@(posedge clk) !rst_n |=> !rd_valid);

    // R5
    a_r5_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        q_cnt <= CNTW'(DEPTH));

    // R6: a confirmed start while full and unread leaves the occupancy as it was
    a_r6_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ok && q_full && !rd_pop) |=> (q_cnt == $past(q_cnt)));

    // R6: nothing is stored while full without a read
    a_r6_no_store_full: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !rd_pop) |-> !q_push);

    // R7: the head and its flags stay put until it is read
    a_r7_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_pop) |=>
            (rd_valid && $stable(rd_data) && $stable(rd_ferr) && $stable(rd_ovr)));

    // R8
    a_r8_pop_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_pop && !q_push) |=> ((q_cnt + CNTW'(1)) == $past(q_cnt)));

    // R9
    a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && !q_push) |=> !rd_valid);
endmodule

bind uart_rx3 uart_rx3_chk #(.DEPTH(DEPTH), .DW(uart_rx3_pkg::DATA_BITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_pop  (rd_pop),
    .rd_valid(rd_valid),
    .rd_ferr (rd_ferr),
    .rd_ovr  (rd_ovr),
    .rd_data (rd_data),
    .st_ok   (st_ok),
    .q_cnt   (q_cnt),
    .q_full  (q_full),
    .q_push  (q_push)
);

// File: tb/tb_uart_rx3.sv
`timescale 1ns/1ps
module tb_uart_rx3;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       os_tick = 1'b0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid, rd_ferr, rd_ovr;

    int n_chk = 0;
    int n_bad = 0;

    // reference queue
    logic [7:0] mdata [3];
    logic       mferr [3];
    logic       movr  [3];
    int         mcnt = 0;

    always #10 clk = ~clk;

    uart_rx3 dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_ferr(rd_ferr), .rd_ovr(rd_ovr)
    );

    initial begin
        logic [1:0] div = 2'd0;
        forever begin
            @(negedge clk);
            div     = div + 2'd1;
            os_tick = (div == 2'd3);
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_head(input string tag);
        logic [10:0] act, exp;
        act = {rd_valid, rd_ovr, rd_ferr, rd_data};
        if (mcnt == 0) begin
            chk(!rd_valid, tag, {31'd0, rd_valid}, 32'd0);
        end else begin
            exp = {1'b1, movr[0], mferr[0], mdata[0]};
            chk(act == exp, tag, {21'd0, act}, {21'd0, exp});
        end
    endtask

    function automatic void model_pop();
        if (mcnt > 0) begin
            for (int i = 0; i < 2; i++) begin
                mdata[i] = mdata[i+1]; mferr[i] = mferr[i+1]; movr[i] = movr[i+1];
            end
            mcnt--;
        end
    endfunction

    function automatic void model_push(input logic [7:0] d, input logic fe);
        if (mcnt < 3) begin
            mdata[mcnt] = d; mferr[mcnt] = fe; movr[mcnt] = 1'b0;
            mcnt++;
        end
    endfunction

    // called at a negedge; checks the head, then reads it
    task automatic do_pop(input string tag);
        check_head(tag);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        model_pop();
    endtask

    task automatic wait_tick();
        do @(posedge clk); while (!os_tick);
        @(negedge clk);
    endtask

    function automatic logic level(input logic [7:0] d, input bit sok, input int g, input int s);
        logic v;
        if (s < 16) return 1'b0;
        if (s < 144) begin
            v = d[(s - 16) / 16];
            if (((s - 16) / 16) == g && (s % 16) == 8) v = ~v;
            return v;
        end
        return sok;
    endfunction

    task automatic send_frame(input logic [7:0] d, input bit sok, input int g,
                              input int p1, input int p2, input string tag);
        bit drop;
        drop = (mcnt == 3);
        if (drop) movr[2] = 1'b1;
        for (int s = 0; s < 160; s++) begin
            wait_tick();
            rxd = level(d, sok, g, s);
            if (s == p1 || s == p2) do_pop(tag);
        end
        wait_tick();
        rxd = 1'b1;
        if (!drop) model_push(d, ~sok);
        repeat (6) wait_tick();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        @(negedge clk);
        check_head("R1 in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_head("R1 after reset");

        // R9: read on empty queue
        do_pop("R9 before empty read");
        @(negedge clk);
        check_head("R9 after empty read");

        // R2: clean frame
        send_frame(8'hA5, 1'b1, -1, -1, -1, "R2");
        check_head("R2 clean frame A5");
        do_pop("R8 pop A5");
        check_head("R8 empty after pop");

        // R4: low stop bit
        send_frame(8'h3C, 1'b0, -1, -1, -1, "R4");
        check_head("R4 stop bit low");
        do_pop("R4 pop");

        // R3: runt start
        for (int s = 0; s < 4; s++) begin wait_tick(); rxd = 1'b0; end
        wait_tick(); rxd = 1'b1;
        repeat (30) wait_tick();
        check_head("R3 runt start rejected");

        // R10: wrong sample at position 8
        send_frame(8'h55, 1'b1, 3, -1, -1, "R10");
        check_head("R10 majority vote bit3");
        send_frame(8'h81, 1'b1, 7, -1, -1, "R10");
        do_pop("R10 pop 55");
        check_head("R10 majority vote bit7");
        do_pop("R10 pop 81");

        // R5 / R6: fill to three, then a fourth without reads
        send_frame(8'h11, 1'b1, -1, -1, -1, "R5");
        send_frame(8'h22, 1'b0, -1, -1, -1, "R5");
        send_frame(8'h33, 1'b1, -1, -1, -1, "R5");
        check_head("R5 three held, head 11");
        send_frame(8'h44, 1'b1, -1, -1, -1, "R6");
        check_head("R6 head after overrun");
        do_pop("R6 drain 11");
        do_pop("R6 drain 22 ferr kept");
        check_head("R6 newest 33 flagged");
        do_pop("R6 drain 33");
        check_head("R6 fourth dropped");

        // R7: reads just after the fourth start and in mid frame
        send_frame(8'h61, 1'b1, -1, -1, -1, "R7");
        send_frame(8'h62, 1'b1, -1, -1, -1, "R7");
        send_frame(8'h63, 1'b1, -1, -1, -1, "R7");
        send_frame(8'h7E, 1'b0, -1, 12, 40, "R7 mid-frame read");
        check_head("R7 ovr kept on 63, ferr 0");
        do_pop("R7 pop 63");
        check_head("R7 fourth dropped");

        // random traffic
        for (int k = 0; k < 45; k++) begin
            logic [7:0] d;
            bit sok;
            int g;
            int np;
            np  = int'($urandom % 3);
            for (int j = 0; j < np; j++) do_pop("R8 random read");
            d   = 8'($urandom);
            sok = ($urandom % 6) != 0;
            g   = (($urandom % 3) == 0) ? int'($urandom % 8) : -1;
            send_frame(d, sok, g, -1, -1, "R2 random");
            check_head("R2 R4 R6 random head");
        end
        while (mcnt > 0) do_pop("R8 final drain");
        check_head("R8 drained");

        summary();
        $finish;
    end
endmodule